// File: doc/BRIEF.md
# FIFO Threshold Offset Load Sequencer

This block keeps the two programmable thresholds that a FIFO's flag logic compares against. One value sets how close to empty the FIFO must be before the almost-empty flag is raised. The other sets how close to full it must be before the almost-full flag is raised. Both are loaded from the low bits of the FIFO data input bus while an active-low load strobe is held. A one-bit sequence pointer decides which of the two registers the next access reaches. The pointer advances on every access and wraps, so one strobe walks through the pair as many times as needed.

The same pointer order applies on the read side. With the load strobe low, a read-enable access copies the selected threshold into an 18-bit readback word, zero-extended above bit 11. The pointer is not cleared when the strobe is released. A sequence can therefore stop after one register and pick up later at the other, whether the next access is a write or a read. The two threshold values drive the flag comparators continuously.

Top module: `offs_load_seq`

## Requirements
- R1: Reset (synchronous, active high) sets both thresholds to 0x07F and the readback word to zero. It also returns the pointer to the almost-empty register, so the first access after reset reaches that register.
- R2: A write-clock rising edge with ld_n=0 and wen_n=0 loads the selected register. With the pointer at its reset position this is the almost-empty threshold, and the next such edge loads the almost-full threshold.
- R3: A third load edge wraps back to the almost-empty threshold, and loads keep alternating between the two registers after that.
- R4: Raising ld_n does not reset the pointer. The next load access reaches the register after the last one accessed.
- R5: A write-clock edge with ld_n=0 and wen_n=1 changes neither threshold and does not move the pointer.
- R6: A write-clock edge with ld_n=1 and wen_n=0 is a normal FIFO write. It changes neither threshold and does not move the pointer.
- R7: A load takes only din[11:0]. Bits din[17:12] have no effect on the stored threshold.
- R8: A read-clock rising edge with ld_n=0 and ren_n=0 puts the selected threshold into rd_word[11:0], with rd_word[17:12]=0, and advances the pointer in the same order used for writes.
- R9: Reads and writes share one pointer. After one readback from the almost-empty register, the next load writes the almost-full register.
- R10: A read-clock edge without ld_n=0 and ren_n=0 together leaves rd_word unchanged and does not move the pointer.
- R11: A loaded value appears on its threshold output on the write-clock edge that stores it, so it is visible in the cycle after the load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock |
| rst | input | 1 | Synchronous active-high reset, applied in both clock domains |
| ld_n | input | 1 | Active-low load strobe that selects threshold access |
| wen_n | input | 1 | Active-low write enable |
| ren_n | input | 1 | Active-low read enable |
| din | input | 18 | FIFO data input; bits 11:0 carry the threshold value |
| empty_off | output | 12 | Almost-empty threshold |
| full_off | output | 12 | Almost-full threshold |
| rd_word | output | 18 | Registered readback word, zero-extended threshold |

## Verification
The hardest case to reach from the ports is a pointer left at the almost-full register by a partial sequence and then used by the other side. This is a read following writes, or a write following a read, with the strobe released and ignored accesses in between. The stimulus stops a load sequence after an odd number of writes. It then applies load-only and write-only cycles, resumes loading, reads back, and finally writes after a single read. At each step it checks which register is reached.

// File: rtl/offs_pkg.sv
package offs_pkg;

    localparam int DATA_W_DEF = 18;
    localparam int OFFS_W_DEF = 12;
    localparam logic [OFFS_W_DEF-1:0] OFFS_RST_DEF = 12'h07F;

    typedef enum logic {
        SEL_EMPTY = 1'b0,
        SEL_FULL  = 1'b1
    } offs_sel_e;

    // The shared pointer is the parity of the two per-domain step counts.
    function automatic offs_sel_e sel_from_toggles(input logic wr_t, input logic rd_t);
        return offs_sel_e'(wr_t ^ rd_t);
    endfunction

endpackage

// File: rtl/offs_toggle.sv
module offs_toggle (
    input  logic clk,
    input  logic rst,
    input  logic step,
    output logic tog
);
    always_ff @(posedge clk) begin
        if (rst)       tog <= 1'b0;
        else if (step) tog <= ~tog;
    end
endmodule

// File: rtl/offs_reg_bank.sv
module offs_reg_bank
    import offs_pkg::*;
#(
    parameter int DATA_W = DATA_W_DEF,
    parameter int OFFS_W = OFFS_W_DEF,
    parameter logic [OFFS_W-1:0] RST_VAL = OFFS_RST_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ld_n,
    input  logic              wen_n,
    input  logic [DATA_W-1:0] din,
    input  offs_sel_e         sel,
    output logic              step,
    output logic [OFFS_W-1:0] empty_off,
    output logic [OFFS_W-1:0] full_off
);
    logic [OFFS_W-1:0] value;

    assign step  = ~ld_n & ~wen_n;
    assign value = din[OFFS_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            empty_off <= RST_VAL;
            full_off  <= RST_VAL;
        end else if (step) begin
            if (sel == SEL_EMPTY) empty_off <= value;
            else                  full_off  <= value;
        end
    end

    // R5
    noop_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!ld_n && wen_n) |=> ($stable(empty_off) && $stable(full_off)));
    // R6
    fifo_write_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (ld_n) |=> ($stable(empty_off) && $stable(full_off)));
    // R2
    other_reg_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (step && sel == SEL_EMPTY) |=> $stable(full_off));
    // R11
    load_visible_chk: assert property (@(posedge clk) disable iff (rst)
        (step && sel == SEL_FULL) |=> (full_off == $past(din[OFFS_W-1:0])));
endmodule

// File: rtl/offs_readback.sv
module offs_readback
    import offs_pkg::*;
#(
    parameter int DATA_W = DATA_W_DEF,
    parameter int OFFS_W = OFFS_W_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ld_n,
    input  logic              ren_n,
    input  offs_sel_e         sel,
    input  logic [OFFS_W-1:0] empty_off,
    input  logic [OFFS_W-1:0] full_off,
    output logic              step,
    output logic [DATA_W-1:0] rd_word
);
    localparam int PAD_W = DATA_W - OFFS_W;

    logic [OFFS_W-1:0] picked;

    assign step   = ~ld_n & ~ren_n;
    assign picked = (sel == SEL_EMPTY) ? empty_off : full_off;

    always_ff @(posedge clk) begin
        if (rst)       rd_word <= '0;
        else if (step) rd_word <= {{PAD_W{1'b0}}, picked};
    end

    // R10
    rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!step) |=> $stable(rd_word));
    // R8
    rd_zero_ext_chk: assert property (@(posedge clk) disable iff (rst)
        step |=> (rd_word[DATA_W-1:OFFS_W] == '0));
endmodule

// File: rtl/offs_load_seq.sv
module offs_load_seq
    import offs_pkg::*;
#(
    parameter int DATA_W = DATA_W_DEF,
    parameter int OFFS_W = OFFS_W_DEF,
    parameter logic [OFFS_W-1:0] RST_VAL = OFFS_RST_DEF
) (
    input  logic              wr_clk,
    input  logic              rd_clk,
    input  logic              rst,
    input  logic              ld_n,
    input  logic              wen_n,
    input  logic              ren_n,
    input  logic [DATA_W-1:0] din,
    output logic [OFFS_W-1:0] empty_off,
    output logic [OFFS_W-1:0] full_off,
    output logic [DATA_W-1:0] rd_word
);
    logic      wr_step, rd_step;
    logic      wr_tog, rd_tog;
    offs_sel_e sel;

    assign sel = sel_from_toggles(wr_tog, rd_tog);

    offs_toggle u_wr_tog (.clk(wr_clk), .rst(rst), .step(wr_step), .tog(wr_tog));
    offs_toggle u_rd_tog (.clk(rd_clk), .rst(rst), .step(rd_step), .tog(rd_tog));

    offs_reg_bank #(.DATA_W(DATA_W), .OFFS_W(OFFS_W), .RST_VAL(RST_VAL)) u_bank (
        .clk(wr_clk), .rst(rst), .ld_n(ld_n), .wen_n(wen_n), .din(din),
        .sel(sel), .step(wr_step), .empty_off(empty_off), .full_off(full_off)
    );

    offs_readback #(.DATA_W(DATA_W), .OFFS_W(OFFS_W)) u_rdbk (
        .clk(rd_clk), .rst(rst), .ld_n(ld_n), .ren_n(ren_n), .sel(sel),
        .empty_off(empty_off), .full_off(full_off), .step(rd_step), .rd_word(rd_word)
    );

    // R1
    rst_defaults_chk: assert property (@(posedge wr_clk)
        $past(rst) |-> (empty_off == RST_VAL && full_off == RST_VAL));
    // R4
    wr_ptr_hold_chk: assert property (@(posedge wr_clk) disable iff (rst)
        (!wr_step) |=> $stable(wr_tog));
endmodule

// File: tb/offs_load_seq_bench.sv
module offs_load_seq_bench;
    logic        clk = 1'b0;
    logic        rst, ld_n, wen_n, ren_n;
    logic [17:0] din;
    logic [11:0] empty_off, full_off;
    logic [17:0] rd_word;
    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    offs_load_seq u_offs_load_seq (
        .wr_clk(clk), .rd_clk(clk), .rst(rst), .ld_n(ld_n), .wen_n(wen_n),
        .ren_n(ren_n), .din(din), .empty_off(empty_off), .full_off(full_off),
        .rd_word(rd_word)
    );

    task automatic chk(input string req, input logic [17:0] got, input logic [17:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    // Drive at the falling edge, let one rising edge act, return at the next falling edge.
    task automatic cyc(input logic l, input logic w, input logic r, input logic [17:0] d);
        ld_n = l; wen_n = w; ren_n = r; din = d;
        @(negedge clk);
    endtask

    task automatic t_reset;
        rst = 1'b1;
        cyc(1, 1, 1, 18'h0);
        cyc(1, 1, 1, 18'h0);
        rst = 1'b0;
        chk("R1 empty", {6'h0, empty_off}, 18'h07F);
        chk("R1 full", {6'h0, full_off}, 18'h07F);
        chk("R1 rd_word", rd_word, 18'h0);
    endtask

    task automatic t_load_pair;
        cyc(0, 0, 1, 18'h3F123);
        chk("R2 R7 R11 empty", {6'h0, empty_off}, 18'h123);
        chk("R2 full untouched", {6'h0, full_off}, 18'h07F);
        cyc(0, 0, 1, 18'h00456);
        chk("R2 full", {6'h0, full_off}, 18'h456);
        chk("R2 empty kept", {6'h0, empty_off}, 18'h123);
    endtask

    task automatic t_wrap;
        cyc(0, 0, 1, 18'h20789);
        chk("R3 wrap empty", {6'h0, empty_off}, 18'h789);
        chk("R3 full kept", {6'h0, full_off}, 18'h456);
    endtask

    task automatic t_ignored_and_resume;
        cyc(1, 1, 1, 18'h0);
        cyc(0, 1, 1, 18'h00ABC);
        chk("R5 empty", {6'h0, empty_off}, 18'h789);
        chk("R5 full", {6'h0, full_off}, 18'h456);
        cyc(1, 0, 1, 18'h00DEF);
        chk("R6 empty", {6'h0, empty_off}, 18'h789);
        chk("R6 full", {6'h0, full_off}, 18'h456);
        cyc(0, 0, 1, 18'h0C0AA);
        chk("R4 resume full", {6'h0, full_off}, 18'h0AA);
        chk("R4 empty kept", {6'h0, empty_off}, 18'h789);
    endtask

    task automatic t_readback;
        cyc(0, 1, 0, 18'h0);
        chk("R8 read empty", rd_word, 18'h00789);
        cyc(0, 1, 0, 18'h0);
        chk("R8 read full", rd_word, 18'h000AA);
        cyc(0, 1, 1, 18'h0);
        chk("R10 ren high hold", rd_word, 18'h000AA);
        cyc(1, 1, 0, 18'h0);
        chk("R10 ld high hold", rd_word, 18'h000AA);
        cyc(0, 1, 0, 18'h0);
        chk("R10 R8 pointer kept", rd_word, 18'h00789);
        cyc(1, 1, 1, 18'h0);
        cyc(0, 0, 1, 18'h00555);
        chk("R9 shared full", {6'h0, full_off}, 18'h555);
        chk("R9 empty kept", {6'h0, empty_off}, 18'h789);
    endtask

    task automatic t_reset_pointer;
        cyc(0, 0, 1, 18'h00321);
        chk("R3 alternate empty", {6'h0, empty_off}, 18'h321);
        rst = 1'b1;
        cyc(1, 1, 1, 18'h0);
        rst = 1'b0;
        chk("R1 empty after rst", {6'h0, empty_off}, 18'h07F);
        cyc(0, 0, 1, 18'h00111);
        chk("R1 pointer to empty", {6'h0, empty_off}, 18'h111);
        chk("R1 full default", {6'h0, full_off}, 18'h07F);
    endtask

    initial begin
        rst = 1'b1; ld_n = 1'b1; wen_n = 1'b1; ren_n = 1'b1; din = '0;
        @(negedge clk);
        t_reset;
        t_load_pair;
        t_wrap;
        t_ignored_and_resume;
        t_readback;
        t_reset_pointer;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #20000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog got=hung exp=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule